// File: doc/BRIEF.md
# Serial Programming Target Receiver

This block is the device side of a four-byte serial programming link. An external programmer holds a hold input high to put the device into programming mode, then clocks instructions in on a serial data input against a serial clock. The block oversamples the serial clock with a fast system clock. It frames the incoming bits into bytes and four-byte instructions, and drives a serial data output that returns bytes to the programmer.

Instructions work on two small byte-wide arrays: a program array and a data array. The first instruction must be a programming-enable key. During the third byte of every instruction, the second byte is echoed back, so the programmer can confirm it is in step. A chip-erase instruction sets both arrays to all ones. A program-array write can only clear bits. A data-array write erases its byte first, so it stores the new value exactly. Reads return the addressed byte during the fourth byte.

The block also checks the minimum width of each serial clock phase, counted in system clocks. A violation sets a sticky error flag.

Top module: `serprog_target`

## Requirements
- R1: Serial input bits are taken on rising serial-clock edges, MSB first, while hold is high. Every eight bits form a byte, and every four bytes form an instruction.
- R2: The serial output changes only on falling serial-clock edges. The byte shifted out during an instruction byte is loaded after the last rising edge of the byte before it, and is sent MSB first.
- R3: During the third byte of any instruction, the serial output carries the second byte of that same instruction.
- R4: The instruction 0xAC 0x53 xx xx enables programming. An instruction with 0xAC and any other second byte does not enable, but all four of its bytes are still consumed, so the next instruction stays framed.
- R5: Until programming is enabled, every write, erase and read instruction is ignored. Reads return 0x00 and the arrays are left unchanged.
- R6: Once enabled, the instruction 0xAC 0x80 xx xx sets every byte of both arrays to 0xFF.
- R7: Once enabled, the instruction 0x40 hi lo dd stores (old AND dd) into the program array. There is no erase before the write.
- R8: Once enabled, the instruction 0xC0 hi lo dd stores exactly dd into the data array. The byte is erased before it is written.
- R9: Once enabled, the instruction 0x20 hi lo xx returns the program byte on the output during the fourth byte, and 0xA0 hi lo xx does the same for the data byte. The address {hi,lo} is taken modulo the array depth.
- R10: While hold is low, the output enable is low, the framing returns to bit 7 of byte 0, and the enable is cleared.
- R11: A serial-clock phase is too short if it lasts fewer than 3 system clocks (or fewer than 4 when FAST_CLK=1). A too-short phase sets timing_err_o, which stays set until reset. The first phase after reset is not checked.
- R12: After reset, both arrays read 0xFF, and timing_err_o and miso_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_hold_i | input | 1 | High selects programming mode (asynchronous) |
| sck_i | input | 1 | Serial clock from the programmer (asynchronous) |
| mosi_i | input | 1 | Serial data into the device |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe_o | output | 1 | Output enable for miso_o |
| timing_err_o | output | 1 | Sticky serial-clock phase width violation |

## Verification
A wrong bit or byte counter shows up within one instruction as a misplaced echo in the third byte. It also causes the next instruction to be misread, so a read that follows returns the wrong value. A wrong enable or array state shows up on the next read instruction's fourth byte. Each test pairs a write with an immediate readback, so such faults appear within two instructions. A phase-width counter that is off by one cycle shows on timing_err_o a few cycles after the boundary-length pulse, which is why pulses of 2 and 3 cycles are both applied.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = 4;
    localparam int SLOT_W    = $clog2(CMD_BYTES);
    localparam int BIT_W     = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] KEY_LEAD   = 8'hAC;
    localparam logic [BYTE_W-1:0] KEY_ENABLE = 8'h53;
    localparam logic [BYTE_W-1:0] KEY_ERASE  = 8'h80;
    localparam logic [BYTE_W-1:0] OP_PWRITE  = 8'h40;
    localparam logic [BYTE_W-1:0] OP_PREAD   = 8'h20;
    localparam logic [BYTE_W-1:0] OP_DWRITE  = 8'hC0;
    localparam logic [BYTE_W-1:0] OP_DREAD   = 8'hA0;

    localparam logic [SLOT_W-1:0] SLOT_ECHO = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CMD_BYTES - 1);
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/serprog_phase.sv
module serprog_phase #(
    parameter bit FAST_CLK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic rise_o,
    output logic fall_o,
    output logic err_o
);
    localparam int MIN_LEN = FAST_CLK ? 4 : 3;
    localparam int CW      = $clog2(MIN_LEN + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_LEN);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          armed;
        logic          err;
    } phase_t;

    phase_t st_d, st_q;
    logic   edge_w;

    always_comb begin
        st_d    = st_q;
        edge_w  = sck_s ^ st_q.prev;
        st_d.prev = sck_s;
        if (edge_w) begin
            st_d.cnt   = CW'(1);
            st_d.armed = 1'b1;
            if (st_q.armed && (st_q.cnt < MIN_C)) st_d.err = 1'b1;
        end else if (st_q.cnt < MIN_C) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        rise_o = sck_s & ~st_q.prev;
        fall_o = ~sck_s & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift
    import serprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_s,
    input  logic              mosi_s,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    typedef struct packed {
        logic [BIT_W-1:0]  bitn;
        logic [SLOT_W-1:0] slot;
        logic [BYTE_W-2:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              ld;
        logic              miso;
        logic              oe;
    } shift_t;

    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

    shift_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ld   = 1'b0;
        st_d.oe   = hold_s;
        rx_byte_o = {st_q.rx, mosi_s};
        done_o    = hold_s & rise_i & (st_q.bitn == '0);
        if (!hold_s) begin
            st_d.bitn = TOP_BIT;
            st_d.slot = '0;
            st_d.tx   = '0;
            st_d.miso = 1'b0;
        end else begin
            if (fall_i) begin
                st_d.miso = st_q.tx[BYTE_W-1];
                st_d.tx   = {st_q.tx[BYTE_W-2:0], 1'b0};
            end
            if (st_q.ld) st_d.tx = tx_byte_i;
            if (rise_i) begin
                st_d.rx = rx_byte_o[BYTE_W-2:0];
                if (st_q.bitn == '0) begin
                    st_d.bitn = TOP_BIT;
                    st_d.slot = st_q.slot + SLOT_W'(1);
                    st_d.ld   = 1'b1;
                end else begin
                    st_d.bitn = st_q.bitn - BIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bitn <= TOP_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o    = st_q.slot;
    assign miso_o    = st_q.miso;
    assign miso_oe_o = st_q.oe;
endmodule

// File: rtl/serprog_mem.sv
module serprog_mem
    import serprog_pkg::*;
#(
    parameter int PROG_DEPTH = 64,
    parameter int DATA_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 erase_i,
    input  logic                 wr_prog_i,
    input  logic                 wr_data_i,
    input  logic                 rd_data_sel_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    output logic [BYTE_W-1:0]    rdata_o
);
    localparam int PAW    = $clog2(PROG_DEPTH);
    localparam int DAW    = $clog2(DATA_DEPTH);
    localparam int ADDR_W = (PAW > DAW) ? PAW : DAW;

    typedef struct packed {
        logic [PROG_DEPTH-1:0][BYTE_W-1:0] prog;
        logic [DATA_DEPTH-1:0][BYTE_W-1:0] data;
    } mem_t;

    mem_t           st_d, st_q;
    logic [PAW-1:0] pa;
    logic [DAW-1:0] da;

    assign pa = addr_i[PAW-1:0];
    assign da = addr_i[DAW-1:0];

    always_comb begin
        st_d = st_q;
        if (erase_i) begin
            st_d.prog = '1;
            st_d.data = '1;
        end else if (wr_prog_i) begin
            st_d.prog[pa] = st_q.prog[pa] & wdata_i;
        end else if (wr_data_i) begin
            st_d.data[da] = wdata_i;
        end
        rdata_o = rd_data_sel_i ? st_q.data[da] : st_q.prog[pa];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/serprog_target.sv
module serprog_target
    import serprog_pkg::*;
#(
    parameter bit FAST_CLK   = 1'b0,
    parameter int PROG_DEPTH = 64,
    parameter int DATA_DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgt_hold_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o,
    output logic timing_err_o
);
    localparam int PAW    = $clog2(PROG_DEPTH);
    localparam int DAW    = $clog2(DATA_DEPTH);
    localparam int ADDR_W = (PAW > DAW) ? PAW : DAW;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
    } ctl_t;

    ctl_t              st_d, st_q;
    logic [2:0]        sync_w;
    logic              hold_s, sck_s, mosi_s;
    logic              sck_rise, sck_fall;
    logic              done;
    logic [BYTE_W-1:0] rx_byte;
    logic [SLOT_W-1:0] slot;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rdata;
    logic              erase, wr_prog, wr_data;
    logic              is_key, is_read;
    logic              en_w;
    logic [BYTE_W-1:0] b0_w, b1_w;

    serprog_sync #(.W(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({tgt_hold_i, sck_i, mosi_i}),
        .sync_o (sync_w)
    );
    assign {hold_s, sck_s, mosi_s} = sync_w;

    serprog_phase #(.FAST_CLK(FAST_CLK)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_s (sck_s),
        .rise_o(sck_rise),
        .fall_o(sck_fall),
        .err_o (timing_err_o)
    );

    serprog_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_s   (hold_s),
        .mosi_s   (mosi_s),
        .rise_i   (sck_rise),
        .fall_i   (sck_fall),
        .tx_byte_i(tx_byte),
        .done_o   (done),
        .rx_byte_o(rx_byte),
        .slot_o   (slot),
        .miso_o   (miso_o),
        .miso_oe_o(miso_oe_o)
    );

    serprog_mem #(.PROG_DEPTH(PROG_DEPTH), .DATA_DEPTH(DATA_DEPTH)) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .erase_i      (erase),
        .wr_prog_i    (wr_prog),
        .wr_data_i    (wr_data),
        .rd_data_sel_i(st_q.b0 == OP_DREAD),
        .addr_i       (ADDR_W'({st_q.b1, st_q.b2})),
        .wdata_i      (rx_byte),
        .rdata_o      (rdata)
    );

    always_comb begin
        st_d    = st_q;
        erase   = 1'b0;
        wr_prog = 1'b0;
        wr_data = 1'b0;
        is_key  = (st_q.b0 == KEY_LEAD);
        if (!hold_s) begin
            st_d.en = 1'b0;
        end else if (done) begin
            case (slot)
                SLOT_W'(0): st_d.b0 = rx_byte;
                SLOT_W'(1): st_d.b1 = rx_byte;
                SLOT_ECHO:  st_d.b2 = rx_byte;
                default: begin
                    if (is_key && (st_q.b1 == KEY_ENABLE)) begin
                        st_d.en = 1'b1;
                    end else if (st_q.en) begin
                        erase   = is_key && (st_q.b1 == KEY_ERASE);
                        wr_prog = (st_q.b0 == OP_PWRITE);
                        wr_data = (st_q.b0 == OP_DWRITE);
                    end
                end
            endcase
        end
        is_read = st_q.en && ((st_q.b0 == OP_PREAD) || (st_q.b0 == OP_DREAD));
        if (slot == SLOT_ECHO)      tx_byte = st_q.b1;
        else if (slot == SLOT_LAST) tx_byte = is_read ? rdata : '0;
        else                        tx_byte = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_w = st_q.en;
    assign b0_w = st_q.b0;
    assign b1_w = st_q.b1;
endmodule

module serprog_target_chk
    import serprog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hold_s,
    input logic              sck_fall,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic              timing_err_o,
    input logic              en_w,
    input logic              done,
    input logic [SLOT_W-1:0] slot,
    input logic [BYTE_W-1:0] b0_w,
    input logic [BYTE_W-1:0] b1_w,
    input logic              erase,
    input logic              wr_prog,
    input logic              wr_data
);
    AST_MISO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_s && !sck_fall) |=> $stable(miso_o)); // R2

    AST_ENABLE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_w) |-> $past(done && (slot == SLOT_LAST) && (b0_w == KEY_LEAD) && (b1_w == KEY_ENABLE))); // R4

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (erase || wr_prog || wr_data) |-> en_w); // R5

    AST_HOLD_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> (!miso_oe_o && !en_w)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err_o |=> timing_err_o); // R11

    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({erase, wr_prog, wr_data}) <= 1); // R6
endmodule

bind serprog_target serprog_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_s      (hold_s),
    .sck_fall    (sck_fall),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o),
    .timing_err_o(timing_err_o),
    .en_w        (en_w),
    .done        (done),
    .slot        (slot),
    .b0_w        (b0_w),
    .b1_w        (b1_w),
    .erase       (erase),
    .wr_prog     (wr_prog),
    .wr_data     (wr_data)
);

// File: tb/serprog_target_tb.sv
`timescale 1ns/1ps
module serprog_target_tb;
    localparam int PH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, oe, err;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    serprog_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgt_hold_i  (hold),
        .sck_i       (sck),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .miso_oe_o   (oe),
        .timing_err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bits sampled just before each rise (resp) and at end of high phase (late)
    task automatic xfer_bits(input logic [31:0] cmd, input int nbits,
                             output logic [31:0] resp, output logic [31:0] late);
        resp = '0;
        late = '0;
        for (int i = 31; i > 31 - nbits; i--) begin
            sck = 1'b0; mosi = cmd[i];
            cyc(PH);
            resp[i] = miso;
            sck = 1'b1;
            cyc(PH);
            late[i] = miso;
        end
        sck = 1'b0;
        cyc(PH);
    endtask

    task automatic xfer(input logic [31:0] cmd, output logic [31:0] resp);
        logic [31:0] late;
        xfer_bits(cmd, 32, resp, late);
    endtask

    task automatic t_reset;
        chk("R12 oe after reset", oe, 1'b0);
        chk("R12 err after reset", err, 1'b0);
    endtask

    task automatic t_locked;
        logic [31:0] r;
        xfer(32'h2000_0500, r);
        chk("R5 read while locked", r[7:0], 8'h00);
        chk("R10 oe high in hold", oe, 1'b1);
        xfer(32'h4000_0500, r);
        xfer(32'hAC12_0000, r);
        chk("R3 echo on bad key", r[15:8], 8'h12);
        xfer(32'h2000_0500, r);
        chk("R4 bad key leaves locked, framing kept", r[7:0], 8'h00);
        chk("R1 echo after bad key framed", r[15:8], 8'h00);
    endtask

    task automatic t_enable;
        logic [31:0] r, late;
        xfer_bits(32'hAC53_0000, 32, r, late);
        chk("R3 enable echo", r[15:8], 8'h53);
        chk("R2 miso stable across rise", late, r);
        xfer(32'h2000_0500, r);
        chk("R12/R5 program byte still erased", r[7:0], 8'hFF);
    endtask

    task automatic t_prog;
        logic [31:0] r;
        xfer(32'h4000_05F0, r);
        chk("R3 echo on write", r[15:8], 8'h00);
        xfer(32'h2000_0500, r);
        chk("R7 first write", r[7:0], 8'hF0);
        xfer(32'h4000_053C, r);
        xfer(32'h2000_0500, r);
        chk("R7 write ANDs old", r[7:0], 8'h30);
        xfer(32'h2000_4500, r);
        chk("R9 program addr wraps", r[7:0], 8'h30);
        xfer(32'h2001_0500, r);
        chk("R9 program high addr wraps", r[7:0], 8'h30);
        chk("R3 echo on read", r[15:8], 8'h01);
    endtask

    task automatic t_data;
        logic [31:0] r;
        xfer(32'hC000_03F0, r);
        xfer(32'hA000_0300, r);
        chk("R8 data first write", r[7:0], 8'hF0);
        xfer(32'hC000_033C, r);
        xfer(32'hA000_0300, r);
        chk("R8 data write overwrites", r[7:0], 8'h3C);
        xfer(32'hA000_1300, r);
        chk("R9 data addr wraps", r[7:0], 8'h3C);
    endtask

    task automatic t_erase;
        logic [31:0] r;
        xfer(32'hAC80_0000, r);
        xfer(32'h2000_0500, r);
        chk("R6 erase program", r[7:0], 8'hFF);
        xfer(32'hA000_0300, r);
        chk("R6 erase data", r[7:0], 8'hFF);
    endtask

    task automatic t_hold;
        logic [31:0] r, late;
        xfer(32'h4000_05A5, r);
        xfer_bits(32'h4000_0700, 12, r, late);
        hold = 1'b0;
        cyc(10);
        chk("R10 oe low when hold low", oe, 1'b0);
        hold = 1'b1;
        cyc(10);
        xfer(32'h2000_0500, r);
        chk("R10 enable cleared by hold", r[7:0], 8'h00);
        xfer(32'hAC53_0000, r);
        chk("R10 framing re-armed", r[15:8], 8'h53);
        xfer(32'h2000_0500, r);
        chk("R10 memory kept, partial write dropped", r[7:0], 8'hA5);
    endtask

    task automatic t_timing;
        hold = 1'b0;
        cyc(10);
        sck = 1'b1; cyc(3); sck = 1'b0; cyc(10);
        chk("R11 3-cycle high accepted", err, 1'b0);
        sck = 1'b1; cyc(10); sck = 1'b0; cyc(3); sck = 1'b1; cyc(10); sck = 1'b0; cyc(10);
        chk("R11 3-cycle low accepted", err, 1'b0);
        sck = 1'b1; cyc(2); sck = 1'b0; cyc(10);
        chk("R11 2-cycle high flagged", err, 1'b1);
        sck = 1'b1; cyc(10); sck = 1'b0; cyc(10);
        chk("R11 flag sticky", err, 1'b1);
        rst_n = 1'b0;
        cyc(3);
        chk("R12 err cleared by reset", err, 1'b0);
        rst_n = 1'b1;
        sck = 1'b1; cyc(10);
        chk("R11 first phase after reset unchecked", err, 1'b0);
        sck = 1'b0; cyc(2); sck = 1'b1; cyc(10); sck = 1'b0; cyc(10);
        chk("R11 2-cycle low flagged", err, 1'b1);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        t_reset();
        hold = 1'b1;
        cyc(8);
        t_locked();
        t_enable();
        t_prog();
        t_data();
        t_erase();
        t_hold();
        t_timing();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule